// File: doc/BRIEF.md
# Packed Attribute Vector Loader

The loader turns a stream of 32-bit register writes into four-component vectors whose components are 24-bit floating-point raw values. It treats the values as plain bit patterns. Three value writes in a row carry one vector. A separate index write chooses the storage slot that the following vectors go to. An index write also cancels any group that is only partly received.

When the third word of a group is accepted, the block splits the 96 bits into four 24-bit components and writes all four into the selected slot of a small attribute array. The components are laid out in reverse order: the first word holds the last component. In the cycle after that, the block shows the committed index and components on a single-cycle strobe. A combinational read port returns any slot by index.

Top module: `attr_vec_loader`

## Requirements
- R1: After reset, `commit_valid_o` is low, every slot reads as zero, and the next three value writes form the first group.
- R2: An index write latches `idx_i`, sets the word position back to the start of a group and drops any words already received for the open group.
- R3: Each accepted value write advances the word position. The third write commits one vector, and the word position then returns to the start of a group.
- R4: Component w equals bits [31:8] of the first word of the group.
- R5: Component z equals {first word [7:0], second word [31:16]}.
- R6: Component y equals {second word [15:0], third word [31:24]}.
- R7: Component x equals bits [23:0] of the third word.
- R8: `commit_valid_o` goes high for exactly one cycle, in the cycle after the clock edge that accepts the third word. While it is high, `commit_idx_o` and the four component outputs carry the committed vector.
- R9: A commit writes all four components of the selected slot at that same edge. Every other slot keeps its contents. `rd_idx_i` reads any slot combinationally.
- R10: When an index write and a value write occur in the same cycle, the index write takes effect and the value word is ignored.
- R11: The selected index stays in force after a commit. Later groups go to the same slot until the next index write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_wr_i | input | 1 | Index write strobe |
| idx_i | input | IDX_W | Destination slot for the following vectors |
| val_wr_i | input | 1 | Value write strobe |
| val_i | input | 32 | Packed value word |
| rd_idx_i | input | IDX_W | Read port slot select |
| rd_x_o | output | 24 | Read port component x |
| rd_y_o | output | 24 | Read port component y |
| rd_z_o | output | 24 | Read port component z |
| rd_w_o | output | 24 | Read port component w |
| commit_valid_o | output | 1 | Single-cycle commit strobe |
| commit_idx_o | output | IDX_W | Slot written by the commit |
| commit_x_o | output | 24 | Committed component x |
| commit_y_o | output | 24 | Committed component y |
| commit_z_o | output | 24 | Committed component z |
| commit_w_o | output | 24 | Committed component w |

## Verification
If the word position is wrong, the strobe shows up one or two writes early or late. The checks catch this at the first group after reset, after an index write, or after a collision between an index write and a value write. If the staging words are wrong, or the components are taken from the wrong bit slices, the values in the strobe cycle are wrong, and the check one cycle after the third word sees it. Each test group uses different patterns in every byte so that each swapped slice stands out. A wrong slot write shows on the read port straight after the commit, both at the target slot and at a neighbouring slot that should not have changed.

// File: rtl/avl_pkg.sv
package avl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned COMP_W = 24;
  localparam int unsigned GROUP_WORDS = 3;

  typedef struct packed {
    logic [COMP_W-1:0] x;
    logic [COMP_W-1:0] y;
    logic [COMP_W-1:0] z;
    logic [COMP_W-1:0] w;
  } vec_t;
endpackage

// File: rtl/avl_stager.sv
module avl_stager
  import avl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic              val_wr_i,
  input  logic [WORD_W-1:0] val_i,
  output logic              fire_o,
  output logic [WORD_W-1:0] w0_o,
  output logic [WORD_W-1:0] w1_o
);
  localparam int unsigned CNT_W = $clog2(GROUP_WORDS);
  localparam int unsigned HELD  = GROUP_WORDS - 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP_WORDS - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] buf_q [HELD];
  logic              take;

  assign take   = val_wr_i && !idx_wr_i;
  assign fire_o = take && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (idx_wr_i) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
    end
  end

  // Last word of a group is consumed straight from the input.
  for (genvar i = 0; i < HELD; i++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[i] <= '0;
      else if (take && cnt_q == CNT_W'(i)) buf_q[i] <= val_i;
    end
  end

  assign w0_o = buf_q[0];
  assign w1_o = buf_q[1];
endmodule

// File: rtl/avl_unpack.sv
module avl_unpack
  import avl_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  input  logic [WORD_W-1:0] w2_i,
  output vec_t              vec_o
);
  logic [3*WORD_W-1:0] cat;

  // Components run backwards: w first, x last.
  assign cat = {w0_i, w1_i, w2_i};
  assign vec_o.w = cat[3*WORD_W-1 -: COMP_W];
  assign vec_o.z = cat[3*WORD_W-1-COMP_W -: COMP_W];
  assign vec_o.y = cat[3*WORD_W-1-2*COMP_W -: COMP_W];
  assign vec_o.x = cat[3*WORD_W-1-3*COMP_W -: COMP_W];
endmodule

// File: rtl/avl_store.sv
module avl_store
  import avl_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  vec_t             wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output vec_t             rdata_o
);
  vec_t mem_q [N_ENTRIES];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[e] <= '0;
      else if (we_i && widx_i == IDX_W'(e)) mem_q[e] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/attr_vec_loader.sv
module attr_vec_loader
  import avl_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              val_wr_i,
  input  logic [WORD_W-1:0] val_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [COMP_W-1:0] rd_x_o,
  output logic [COMP_W-1:0] rd_y_o,
  output logic [COMP_W-1:0] rd_z_o,
  output logic [COMP_W-1:0] rd_w_o,
  output logic              commit_valid_o,
  output logic [IDX_W-1:0]  commit_idx_o,
  output logic [COMP_W-1:0] commit_x_o,
  output logic [COMP_W-1:0] commit_y_o,
  output logic [COMP_W-1:0] commit_z_o,
  output logic [COMP_W-1:0] commit_w_o
);
  logic              fire;
  logic [WORD_W-1:0] w0, w1;
  vec_t              vec, rd_vec, com_q;
  logic [IDX_W-1:0]  idx_q, com_idx_q;
  logic              com_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (idx_wr_i) idx_q <= idx_i;
  end

  avl_stager u_stager (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (idx_wr_i),
    .val_wr_i (val_wr_i),
    .val_i    (val_i),
    .fire_o   (fire),
    .w0_o     (w0),
    .w1_o     (w1)
  );

  avl_unpack u_unpack (
    .w0_i  (w0),
    .w1_i  (w1),
    .w2_i  (val_i),
    .vec_o (vec)
  );

  avl_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (fire),
    .widx_i  (idx_q),
    .wdata_i (vec),
    .ridx_i  (rd_idx_i),
    .rdata_o (rd_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      com_vld_q <= 1'b0;
      com_idx_q <= '0;
      com_q     <= '0;
    end else begin
      com_vld_q <= fire;
      if (fire) begin
        com_idx_q <= idx_q;
        com_q     <= vec;
      end
    end
  end

  assign commit_valid_o = com_vld_q;
  assign commit_idx_o   = com_idx_q;
  assign commit_x_o     = com_q.x;
  assign commit_y_o     = com_q.y;
  assign commit_z_o     = com_q.z;
  assign commit_w_o     = com_q.w;
  assign rd_x_o         = rd_vec.x;
  assign rd_y_o         = rd_vec.y;
  assign rd_z_o         = rd_vec.z;
  assign rd_w_o         = rd_vec.w;
endmodule

// File: rtl/avl_checker.sv
module avl_checker #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idx_wr_i,
  input logic             val_wr_i,
  input logic [31:0]      val_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [23:0]      rd_x_o,
  input logic [23:0]      rd_w_o,
  input logic             commit_valid_o,
  input logic [IDX_W-1:0] commit_idx_o,
  input logic [23:0]      commit_x_o,
  input logic [23:0]      commit_w_o
);
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |=> !commit_valid_o); // R8

  AST_IDX_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |=> !commit_valid_o); // R2

  AST_COMMIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |-> $past(val_wr_i && !idx_wr_i)); // R3

  AST_X_SLICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |-> commit_x_o == $past(val_i[23:0])); // R7

  AST_STORE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_o && rd_idx_i == commit_idx_o) |->
      (rd_x_o == commit_x_o && rd_w_o == commit_w_o)); // R9
endmodule

bind attr_vec_loader avl_checker #(.IDX_W(IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .idx_wr_i       (idx_wr_i),
  .val_wr_i       (val_wr_i),
  .val_i          (val_i),
  .rd_idx_i       (rd_idx_i),
  .rd_x_o         (rd_x_o),
  .rd_w_o         (rd_w_o),
  .commit_valid_o (commit_valid_o),
  .commit_idx_o   (commit_idx_o),
  .commit_x_o     (commit_x_o),
  .commit_w_o     (commit_w_o)
);

// File: tb/tb_attr_vec_loader.sv
module tb_attr_vec_loader;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 0, rst_ni = 0;
  logic idx_wr = 0, val_wr = 0;
  logic [IW-1:0] idx = '0, rd_idx = '0;
  logic [31:0] val = '0;
  logic [23:0] rx, ry, rz, rw, cx, cy, cz, cw;
  logic cv;
  logic [IW-1:0] cidx;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  attr_vec_loader #(.N_ENTRIES(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .idx_wr_i(idx_wr), .idx_i(idx),
    .val_wr_i(val_wr), .val_i(val), .rd_idx_i(rd_idx),
    .rd_x_o(rx), .rd_y_o(ry), .rd_z_o(rz), .rd_w_o(rw),
    .commit_valid_o(cv), .commit_idx_o(cidx),
    .commit_x_o(cx), .commit_y_o(cy), .commit_z_o(cz), .commit_w_o(cw)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_idx(input logic [IW-1:0] i);
    @(negedge clk); idx_wr = 1; idx = i;
    @(negedge clk); idx_wr = 0;
  endtask

  task automatic wr_val(input logic [31:0] v);
    @(negedge clk); val_wr = 1; val = v;
    @(negedge clk); val_wr = 0;
  endtask

  // Checks the strobe cycle right after the third word, then the drop.
  task automatic chk_commit(input logic [31:0] a, b, c, input logic [IW-1:0] i, input string tag);
    logic [23:0] ex, ey, ez, ew;
    ew = a[31:8];
    ez = {a[7:0], b[31:16]};
    ey = {b[15:0], c[31:24]};
    ex = c[23:0];
    chk(cv === 1'b1, {tag, " R8 valid"}, 96'(cv), 96'd1);
    chk(cidx === i, {tag, " R8 R11 idx"}, 96'(cidx), 96'(i));
    chk(cw === ew, {tag, " R4 w"}, 96'(cw), 96'(ew));
    chk(cz === ez, {tag, " R5 z"}, 96'(cz), 96'(ez));
    chk(cy === ey, {tag, " R6 y"}, 96'(cy), 96'(ey));
    chk(cx === ex, {tag, " R7 x"}, 96'(cx), 96'(ex));
    rd_idx = i; #1;
    chk({rx, ry, rz, rw} === {ex, ey, ez, ew}, {tag, " R9 store"}, {rx, ry, rz, rw}, {ex, ey, ez, ew});
    @(negedge clk);
    chk(cv === 1'b0, {tag, " R8 one cycle"}, 96'(cv), 96'd0);
  endtask

  task automatic t_reset;
    bit allz = 1;
    chk(cv === 1'b0, "R1 valid after reset", 96'(cv), 96'd0);
    for (int e = 0; e < N; e++) begin
      rd_idx = IW'(e); #1;
      if ({rx, ry, rz, rw} !== '0) allz = 0;
    end
    chk(allz, "R1 slots zero", 96'(allz), 96'd1);
  endtask

  task automatic t_basic;
    // First group after reset, no index write: slot 0 (R1)
    wr_val(32'h11223344); wr_val(32'h55667788);
    chk(cv === 1'b0, "R3 no early commit", 96'(cv), 96'd0);
    wr_val(32'h99AABBCC);
    chk_commit(32'h11223344, 32'h55667788, 32'h99AABBCC, 4'd0, "R1 first");
    wr_idx(4'd5);
    wr_val(32'hA1B2C3D4); wr_val(32'hE5F60718); wr_val(32'h293A4B5C);
    chk_commit(32'hA1B2C3D4, 32'hE5F60718, 32'h293A4B5C, 4'd5, "R3 basic");
    rd_idx = 4'd4; #1;
    chk({rx, ry, rz, rw} === '0, "R9 neighbour untouched", {rx, ry, rz, rw}, 96'd0);
  endtask

  task automatic t_same_idx;
    wr_val(32'hFEDCBA98); wr_val(32'h76543210); wr_val(32'h0F1E2D3C);
    chk_commit(32'hFEDCBA98, 32'h76543210, 32'h0F1E2D3C, 4'd5, "R11 repeat");
  endtask

  task automatic t_discard;
    wr_idx(4'd3);
    wr_val(32'hDEADBEEF); wr_val(32'hCAFEF00D);
    wr_idx(4'd3);
    wr_val(32'h13579BDF); wr_val(32'h2468ACE0);
    chk(cv === 1'b0, "R2 partial dropped", 96'(cv), 96'd0);
    wr_val(32'hF0E1D2C3);
    chk_commit(32'h13579BDF, 32'h2468ACE0, 32'hF0E1D2C3, 4'd3, "R2 restart");
  endtask

  task automatic t_collide;
    wr_idx(4'd7);
    wr_val(32'h01010101);
    @(negedge clk); idx_wr = 1; idx = 4'd9; val_wr = 1; val = 32'hBADBADBA;
    @(negedge clk); idx_wr = 0; val_wr = 0;
    wr_val(32'h3C4D5E6F); wr_val(32'h708192A3);
    chk(cv === 1'b0, "R10 value ignored", 96'(cv), 96'd0);
    wr_val(32'hB4C5D6E7);
    chk_commit(32'h3C4D5E6F, 32'h708192A3, 32'hB4C5D6E7, 4'd9, "R10 collide");
    rd_idx = 4'd7; #1;
    chk({rx, ry, rz, rw} === '0, "R10 old slot untouched", {rx, ry, rz, rw}, 96'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_same_idx();
    t_discard();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule